// File: doc/BRIEF.md
# Display Power Sequencer

This block brings a TFT panel driver chip through its power states. It does this by issuing scripted register writes, with timed waits between them. Four commands are accepted: power-up, display-on, display-off and sleep. Each command starts a fixed script. The script runs from a computed step store. Every step is one of the following:
- a register write (an 8-bit index and a 16-bit value);
- an index-only selection;
- a wait of a parameterised number of milliseconds;
- a closing step that updates the status flags.

Writes leave through a valid/ready stream toward a serial register writer. `wr_valid` rises when a step has a write ready. The index, value and index-only flag stay unchanged until a cycle with `wr_ready` high accepts the write. The writer applies back-pressure simply by holding `wr_ready` low, and the block stalls on that step. Waits are counted in pulses of an external millisecond tick. Command inputs, the two option bits and the status outputs are plain level signals.

Two shortcuts apply to display-on:
- If the chip is still powered, the full power-up is skipped and only three registers are restored.
- If it is not powered, the whole power-up runs first and then continues straight into the display-on steps.

Top module: `dpwr_seq`

## Requirements
- R1: After reset, `powered`, `display_active`, `busy` and `wr_valid` are all low.
- R2: Power-up writes (index=value, hex) 10=0000 and 00=0001, then waits OSC_MS. Next it writes 10=4444, 11=0001, 12=0003, 13=1119 and 12=0013, then waits RAIL_MS. Next it writes 10=4440 and 13=3119, then waits SETTLE_MS. At the end `powered` is high.
- R3: After the settle wait, power-up writes the following configuration in this order, with no further waits:
  - 01=101B, or 01=131B when the flip option is set;
  - 02=0700, 03=6020, 04=0000, 05=0000, 08=0202, 09=0000, 0B=4400, 0C=0110;
  - 40=0000, 41=0000, 42=DB00, 43=0000, 44=AF00, 45=DB00;
  - 30=0000, 31=0704, 32=0107, 33=0704, 34=0107, 35=0002, 36=0707, 37=0503, 38=0000, 39=0000;
  - 21=00AF, then 0C=0110.
- R4: Display-on with power down first runs the R2/R3 power-up. It then writes 10=4740 and waits GATE_MS. Next it writes register 07 with 0041, waits RAMP_MS, writes 07 with 0061 and then 0063, waits RAMP_MS, and writes 07 with 0073. The last step is an index-only selection of 22 (`wr_index_only` high). After that `display_active` is high.
- R5: Display-on while powered skips the power-up. It writes only 12=0013, 0B=4400 and 13=3119, then continues with the R4 steps from 10=4740 onward.
- R6: Every ramp value written to register 07, in both display-on and display-off, is ORed with 0004 when the invert option is low and with 0000 when it is high.
- R7: Display-off runs only while the display is active. It writes 0B=4000 and 07=0072, waits FADE_MS, writes 07=0062, waits FADE_MS, then writes 07=0000, 10=0000, 12=0003 and 13=1119. After that `display_active` is low.
- R8: Sleep always runs. It first performs the R7 display-off writes if the display is active, then writes 10=0001. After that `powered` and `display_active` are low.
- R9: Commands that arrive while `busy` is high have no effect. So do redundant commands: power-up while powered, display-on while active, and display-off while inactive. None of these produce writes or flag changes.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_index`, `wr_value` and `wr_index_only` hold. `wr_valid` is low whenever `busy` is low.
- R11: A wait of N ms counts N `ms_tick` pulses after it starts. The write after the wait is accepted no sooner than N ticks after the write before it.
- R12: The invert and flip options are captured when a command is accepted. Changing them while a script runs does not affect that script.
- R13: When several commands are high in the same idle cycle, the block picks in this order:
  1. sleep;
  2. display-off, if the display is active;
  3. display-on, if the display is inactive;
  4. power-up, if not powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| cmd_power_up | input | 1 | Request power-up |
| cmd_display_on | input | 1 | Request display enable |
| cmd_display_off | input | 1 | Request display disable |
| cmd_sleep | input | 1 | Request standby |
| opt_invert | input | 1 | Invert option, captured at command accept |
| opt_flip | input | 1 | Flip option, captured at command accept |
| wr_valid | output | 1 | Write step ready for the serial writer |
| wr_ready | input | 1 | Serial writer accepts the write |
| wr_index | output | 8 | Register index |
| wr_value | output | 16 | Register value (zero for an index-only step) |
| wr_index_only | output | 1 | Select the index only, no value phase |
| powered | output | 1 | Driver chip powered |
| display_active | output | 1 | Display enabled |
| busy | output | 1 | A script is running |

## Verification
A wrong program counter or a stale step shows up at once as a wrong index or value on the stream. That error appears at the first write after the fault, in the order the script lists them.

A broken wait timer shows up as too few ticks between the writes on either side of the wait. This is visible as soon as the following write is accepted.

Status flags that are set or cleared at the wrong step show up in two ways:
- `display_active` without `powered`;
- a redundant command that produces writes, or fails to, on the very next command.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned VAL_W = 16;
  localparam int unsigned PC_W  = 7;
  localparam int unsigned GAMMA_N = 10;

  typedef enum logic [2:0] {
    OP_WR, OP_IDX, OP_WAIT, OP_END_PU, OP_END_ON, OP_END_OFF, OP_END_SB
  } op_e;

  typedef enum logic [2:0] {
    W_OSC, W_RAIL, W_SETTLE, W_GATE, W_RAMP, W_FADE
  } wsel_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] val;
    wsel_e            wsel;
  } step_t;

  // script entry points; offsets are the order of the steps
  localparam logic [PC_W-1:0] PC_PWRUP  = 7'd0;
  localparam logic [PC_W-1:0] PC_GAMMA  = 7'd27;
  localparam logic [PC_W-1:0] PC_RESUME = 7'd40;
  localparam logic [PC_W-1:0] PC_ONTAIL = 7'd43;
  localparam logic [PC_W-1:0] PC_OFF    = 7'd53;
  localparam logic [PC_W-1:0] PC_STBY   = 7'd63;

  localparam logic [VAL_W-1:0] NORMAL_BIT = 16'h0004;

  function automatic step_t mk_wr(logic [IDX_W-1:0] i, logic [VAL_W-1:0] v);
    step_t s;
    s.op = OP_WR; s.idx = i; s.val = v; s.wsel = W_OSC;
    return s;
  endfunction

  function automatic step_t mk_idx(logic [IDX_W-1:0] i);
    step_t s;
    s.op = OP_IDX; s.idx = i; s.val = '0; s.wsel = W_OSC;
    return s;
  endfunction

  function automatic step_t mk_wait(wsel_e w);
    step_t s;
    s.op = OP_WAIT; s.idx = '0; s.val = '0; s.wsel = w;
    return s;
  endfunction

  function automatic step_t mk_end(op_e o);
    step_t s;
    s.op = o; s.idx = '0; s.val = '0; s.wsel = W_OSC;
    return s;
  endfunction

  function automatic logic [VAL_W-1:0] gamma_val(logic [3:0] k);
    case (k)
      4'd1, 4'd3: gamma_val = 16'h0704;
      4'd2, 4'd4: gamma_val = 16'h0107;
      4'd5:       gamma_val = 16'h0002;
      4'd6:       gamma_val = 16'h0707;
      4'd7:       gamma_val = 16'h0503;
      default:    gamma_val = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/dps_script.sv
module dps_script
  import dps_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  input  logic            inv,
  input  logic            flip,
  output step_t           step
);
  logic [VAL_W-1:0] rev;
  logic [PC_W-1:0]  goff;

  assign rev  = inv ? '0 : NORMAL_BIT;
  assign goff = pc - PC_GAMMA;

  always_comb begin
    step = mk_end(OP_END_SB);
    if (pc >= PC_GAMMA && pc < PC_GAMMA + PC_W'(GAMMA_N)) begin
      step = mk_wr(8'h30 + IDX_W'(goff), gamma_val(goff[3:0]));
    end else begin
      case (pc)
        // power-up: oscillator and rails
        7'd0:  step = mk_wr(8'h10, 16'h0000);
        7'd1:  step = mk_wr(8'h00, 16'h0001);
        7'd2:  step = mk_wait(W_OSC);
        7'd3:  step = mk_wr(8'h10, 16'h4444);
        7'd4:  step = mk_wr(8'h11, 16'h0001);
        7'd5:  step = mk_wr(8'h12, 16'h0003);
        7'd6:  step = mk_wr(8'h13, 16'h1119);
        7'd7:  step = mk_wr(8'h12, 16'h0013);
        7'd8:  step = mk_wait(W_RAIL);
        7'd9:  step = mk_wr(8'h10, 16'h4440);
        7'd10: step = mk_wr(8'h13, 16'h3119);
        7'd11: step = mk_wait(W_SETTLE);
        // power-up: configuration
        7'd12: step = mk_wr(8'h01, flip ? 16'h131B : 16'h101B);
        7'd13: step = mk_wr(8'h02, 16'h0700);
        7'd14: step = mk_wr(8'h03, 16'h6020);
        7'd15: step = mk_wr(8'h04, 16'h0000);
        7'd16: step = mk_wr(8'h05, 16'h0000);
        7'd17: step = mk_wr(8'h08, 16'h0202);
        7'd18: step = mk_wr(8'h09, 16'h0000);
        7'd19: step = mk_wr(8'h0B, 16'h4400);
        7'd20: step = mk_wr(8'h0C, 16'h0110);
        7'd21: step = mk_wr(8'h40, 16'h0000);
        7'd22: step = mk_wr(8'h41, 16'h0000);
        7'd23: step = mk_wr(8'h42, 16'hDB00);
        7'd24: step = mk_wr(8'h43, 16'h0000);
        7'd25: step = mk_wr(8'h44, 16'hAF00);
        7'd26: step = mk_wr(8'h45, 16'hDB00);
        7'd37: step = mk_wr(8'h21, 16'h00AF);
        7'd38: step = mk_wr(8'h0C, 16'h0110);
        7'd39: step = mk_end(OP_END_PU);
        // resume while powered
        7'd40: step = mk_wr(8'h12, 16'h0013);
        7'd41: step = mk_wr(8'h0B, 16'h4400);
        7'd42: step = mk_wr(8'h13, 16'h3119);
        // display enable ramp
        7'd43: step = mk_wr(8'h10, 16'h4740);
        7'd44: step = mk_wait(W_GATE);
        7'd45: step = mk_wr(8'h07, 16'h0041 | rev);
        7'd46: step = mk_wait(W_RAMP);
        7'd47: step = mk_wr(8'h07, 16'h0061 | rev);
        7'd48: step = mk_wr(8'h07, 16'h0063 | rev);
        7'd49: step = mk_wait(W_RAMP);
        7'd50: step = mk_wr(8'h07, 16'h0073 | rev);
        7'd51: step = mk_idx(8'h22);
        7'd52: step = mk_end(OP_END_ON);
        // display disable
        7'd53: step = mk_wr(8'h0B, 16'h4000);
        7'd54: step = mk_wr(8'h07, 16'h0072 | rev);
        7'd55: step = mk_wait(W_FADE);
        7'd56: step = mk_wr(8'h07, 16'h0062 | rev);
        7'd57: step = mk_wait(W_FADE);
        7'd58: step = mk_wr(8'h07, 16'h0000);
        7'd59: step = mk_wr(8'h10, 16'h0000);
        7'd60: step = mk_wr(8'h12, 16'h0003);
        7'd61: step = mk_wr(8'h13, 16'h1119);
        7'd62: step = mk_end(OP_END_OFF);
        // standby
        7'd63: step = mk_wr(8'h10, 16'h0001);
        default: step = mk_end(OP_END_SB);
      endcase
    end
  end
endmodule

// File: rtl/dps_wait_timer.sv
module dps_wait_timer
  import dps_pkg::*;
#(
  parameter int unsigned OSC_MS    = 20,
  parameter int unsigned RAIL_MS   = 40,
  parameter int unsigned SETTLE_MS = 167,
  parameter int unsigned GATE_MS   = 40,
  parameter int unsigned RAMP_MS   = 33,
  parameter int unsigned FADE_MS   = 40
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  wsel_e sel,
  input  logic  tick,
  output logic  expired
);
  localparam int unsigned SUM_MS = OSC_MS + RAIL_MS + SETTLE_MS + GATE_MS + RAMP_MS + FADE_MS;
  localparam int unsigned CW     = $clog2(SUM_MS + 2);

  logic [CW-1:0] cnt, dur;

  always_comb begin
    case (sel)
      W_OSC:    dur = CW'(OSC_MS);
      W_RAIL:   dur = CW'(RAIL_MS);
      W_SETTLE: dur = CW'(SETTLE_MS);
      W_GATE:   dur = CW'(GATE_MS);
      W_RAMP:   dur = CW'(RAMP_MS);
      default:  dur = CW'(FADE_MS);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= dur;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dps_cmd_arb.sv
module dps_cmd_arb
  import dps_pkg::*;
(
  input  logic            req_power,
  input  logic            req_on,
  input  logic            req_off,
  input  logic            req_sleep,
  input  logic            powered,
  input  logic            disp,
  output logic            start,
  output logic [PC_W-1:0] entry,
  output logic            chain_on,
  output logic            chain_sleep
);
  always_comb begin
    start       = 1'b0;
    entry       = PC_PWRUP;
    chain_on    = 1'b0;
    chain_sleep = 1'b0;
    if (req_sleep) begin
      start       = 1'b1;
      chain_sleep = 1'b1;
      entry       = disp ? PC_OFF : PC_STBY;
    end else if (req_off && disp) begin
      start = 1'b1;
      entry = PC_OFF;
    end else if (req_on && !disp) begin
      start    = 1'b1;
      chain_on = 1'b1;
      entry    = powered ? PC_RESUME : PC_PWRUP;
    end else if (req_power && !powered) begin
      start = 1'b1;
      entry = PC_PWRUP;
    end
  end
endmodule

// File: rtl/dpwr_seq.sv
module dpwr_seq
  import dps_pkg::*;
#(
  parameter int unsigned OSC_MS    = 20,
  parameter int unsigned RAIL_MS   = 40,
  parameter int unsigned SETTLE_MS = 167,
  parameter int unsigned GATE_MS   = 40,
  parameter int unsigned RAMP_MS   = 33,
  parameter int unsigned FADE_MS   = 40
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             cmd_power_up,
  input  logic             cmd_display_on,
  input  logic             cmd_display_off,
  input  logic             cmd_sleep,
  input  logic             opt_invert,
  input  logic             opt_flip,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [IDX_W-1:0] wr_index,
  output logic [VAL_W-1:0] wr_value,
  output logic             wr_index_only,
  output logic             powered,
  output logic             display_active,
  output logic             busy
);
  logic            running, armed, chain_on_q, chain_sleep_q, inv_q, flip_q;
  logic [PC_W-1:0] pc;
  step_t           step;
  logic            start, chain_on, chain_sleep, expired, tmr_load;
  logic [PC_W-1:0] entry;

  dps_cmd_arb u_arb (
    .req_power  (cmd_power_up),
    .req_on     (cmd_display_on),
    .req_off    (cmd_display_off),
    .req_sleep  (cmd_sleep),
    .powered    (powered),
    .disp       (display_active),
    .start      (start),
    .entry      (entry),
    .chain_on   (chain_on),
    .chain_sleep(chain_sleep)
  );

  dps_script u_script (
    .pc  (pc),
    .inv (inv_q),
    .flip(flip_q),
    .step(step)
  );

  assign tmr_load = running && step.op == OP_WAIT && !armed;

  dps_wait_timer #(
    .OSC_MS(OSC_MS), .RAIL_MS(RAIL_MS), .SETTLE_MS(SETTLE_MS),
    .GATE_MS(GATE_MS), .RAMP_MS(RAMP_MS), .FADE_MS(FADE_MS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .sel    (step.wsel),
    .tick   (ms_tick),
    .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running        <= 1'b0;
      armed          <= 1'b0;
      pc             <= PC_PWRUP;
      chain_on_q     <= 1'b0;
      chain_sleep_q  <= 1'b0;
      inv_q          <= 1'b0;
      flip_q         <= 1'b0;
      powered        <= 1'b0;
      display_active <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running       <= 1'b1;
        armed         <= 1'b0;
        pc            <= entry;
        chain_on_q    <= chain_on;
        chain_sleep_q <= chain_sleep;
        inv_q         <= opt_invert;
        flip_q        <= opt_flip;
      end
    end else begin
      case (step.op)
        OP_WR, OP_IDX: if (wr_ready) pc <= pc + 1'b1;
        OP_WAIT: begin
          if (!armed) armed <= 1'b1;
          else if (expired) begin
            armed <= 1'b0;
            pc    <= pc + 1'b1;
          end
        end
        OP_END_PU: begin
          powered <= 1'b1;
          if (chain_on_q) pc <= PC_ONTAIL;
          else            running <= 1'b0;
        end
        OP_END_ON: begin
          display_active <= 1'b1;
          running        <= 1'b0;
        end
        OP_END_OFF: begin
          display_active <= 1'b0;
          if (chain_sleep_q) begin
            powered <= 1'b0;
            pc      <= PC_STBY;
          end else begin
            running <= 1'b0;
          end
        end
        default: begin
          powered <= 1'b0;
          running <= 1'b0;
        end
      endcase
    end
  end

  assign busy          = running;
  assign wr_valid      = running && (step.op == OP_WR || step.op == OP_IDX);
  assign wr_index      = step.idx;
  assign wr_value      = step.val;
  assign wr_index_only = running && step.op == OP_IDX;
endmodule

// File: rtl/dpwr_seq_chk.sv
module dpwr_seq_chk
  import dps_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_power_up,
  input logic             cmd_display_on,
  input logic             cmd_display_off,
  input logic             cmd_sleep,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IDX_W-1:0] wr_index,
  input logic [VAL_W-1:0] wr_value,
  input logic             wr_index_only,
  input logic             powered,
  input logic             display_active,
  input logic             busy
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_index) && $stable(wr_value) && $stable(wr_index_only));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  assert_disp_needs_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
    display_active |-> powered);

  assert_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(display_active) |-> !busy);

  assert_select_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_index_only |-> wr_index == 8'h22);

  assert_flags_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(cmd_power_up || cmd_display_on || cmd_display_off || cmd_sleep)
    |=> $stable(powered) && $stable(display_active));
endmodule

bind dpwr_seq dpwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_power_up(cmd_power_up), .cmd_display_on(cmd_display_on),
  .cmd_display_off(cmd_display_off), .cmd_sleep(cmd_sleep),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index),
  .wr_value(wr_value), .wr_index_only(wr_index_only),
  .powered(powered), .display_active(display_active), .busy(busy)
);

// File: tb/dpwr_seq_test.sv
module dpwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKP = 8;
  localparam int OSC = 3, RAIL = 2, SETTLE = 4, GATE = 2, RAMP = 3, FADE = 2;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic c_pwr = 0, c_on = 0, c_off = 0, c_slp = 0, inv = 0, flip = 0;
  logic wr_valid, wr_ready = 1'b0, wr_index_only, powered, display_active, busy;
  logic [7:0]  wr_index;
  logic [15:0] wr_value;

  int tests = 0, fails = 0, cyc = 0, tick_cnt = 0;
  int ncap = 0, nexp = 0;
  logic [7:0]  g_idx[128], e_idx[128];
  logic [15:0] g_val[128], e_val[128];
  logic        g_io[128],  e_io[128];
  int          g_tk[128],  e_gap[128];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpwr_seq #(.OSC_MS(OSC), .RAIL_MS(RAIL), .SETTLE_MS(SETTLE),
             .GATE_MS(GATE), .RAMP_MS(RAMP), .FADE_MS(FADE)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cmd_power_up(c_pwr), .cmd_display_on(c_on), .cmd_display_off(c_off), .cmd_sleep(c_slp),
    .opt_invert(inv), .opt_flip(flip),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index), .wr_value(wr_value),
    .wr_index_only(wr_index_only), .powered(powered), .display_active(display_active), .busy(busy));

  always @(negedge clk) begin
    cyc++;
    ms_tick  <= (cyc % TICKP) == 0;
    wr_ready <= ((cyc % 5) != 1) && ((cyc % 7) != 3);
  end

  always @(posedge clk) begin
    if (ms_tick) tick_cnt++;
    if (wr_valid && wr_ready && ncap < 128) begin
      g_idx[ncap] = wr_index; g_val[ncap] = wr_value;
      g_io[ncap] = wr_index_only; g_tk[ncap] = tick_cnt;
      ncap++;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired: actual running expected done");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] i, logic [15:0] v, logic io, int gap);
    e_idx[nexp] = i; e_val[nexp] = v; e_io[nexp] = io; e_gap[nexp] = gap;
    nexp++;
  endtask

  function automatic logic [15:0] rv(logic iv);
    return iv ? 16'h0000 : 16'h0004;
  endfunction

  task automatic add_pu(logic fl);
    push(8'h10, 16'h0000, 0, 0); push(8'h00, 16'h0001, 0, 0);
    push(8'h10, 16'h4444, 0, OSC); push(8'h11, 16'h0001, 0, 0);
    push(8'h12, 16'h0003, 0, 0);   push(8'h13, 16'h1119, 0, 0);
    push(8'h12, 16'h0013, 0, 0);   push(8'h10, 16'h4440, 0, RAIL);
    push(8'h13, 16'h3119, 0, 0);
    push(8'h01, fl ? 16'h131B : 16'h101B, 0, SETTLE);
    push(8'h02, 16'h0700, 0, 0); push(8'h03, 16'h6020, 0, 0);
    push(8'h04, 16'h0000, 0, 0); push(8'h05, 16'h0000, 0, 0);
    push(8'h08, 16'h0202, 0, 0); push(8'h09, 16'h0000, 0, 0);
    push(8'h0B, 16'h4400, 0, 0); push(8'h0C, 16'h0110, 0, 0);
    push(8'h40, 16'h0000, 0, 0); push(8'h41, 16'h0000, 0, 0);
    push(8'h42, 16'hDB00, 0, 0); push(8'h43, 16'h0000, 0, 0);
    push(8'h44, 16'hAF00, 0, 0); push(8'h45, 16'hDB00, 0, 0);
    push(8'h30, 16'h0000, 0, 0); push(8'h31, 16'h0704, 0, 0);
    push(8'h32, 16'h0107, 0, 0); push(8'h33, 16'h0704, 0, 0);
    push(8'h34, 16'h0107, 0, 0); push(8'h35, 16'h0002, 0, 0);
    push(8'h36, 16'h0707, 0, 0); push(8'h37, 16'h0503, 0, 0);
    push(8'h38, 16'h0000, 0, 0); push(8'h39, 16'h0000, 0, 0);
    push(8'h21, 16'h00AF, 0, 0); push(8'h0C, 16'h0110, 0, 0);
  endtask

  task automatic add_resume();
    push(8'h12, 16'h0013, 0, 0); push(8'h0B, 16'h4400, 0, 0); push(8'h13, 16'h3119, 0, 0);
  endtask

  task automatic add_tail(logic iv);
    push(8'h10, 16'h4740, 0, 0);
    push(8'h07, 16'h0041 | rv(iv), 0, GATE);
    push(8'h07, 16'h0061 | rv(iv), 0, RAMP);
    push(8'h07, 16'h0063 | rv(iv), 0, 0);
    push(8'h07, 16'h0073 | rv(iv), 0, RAMP);
    push(8'h22, 16'h0000, 1, 0);
  endtask

  task automatic add_off(logic iv);
    push(8'h0B, 16'h4000, 0, 0);
    push(8'h07, 16'h0072 | rv(iv), 0, 0);
    push(8'h07, 16'h0062 | rv(iv), 0, FADE);
    push(8'h07, 16'h0000, 0, FADE);
    push(8'h10, 16'h0000, 0, 0); push(8'h12, 16'h0003, 0, 0); push(8'h13, 16'h1119, 0, 0);
  endtask

  // pulse commands for one cycle, optionally poke others mid-run, wait for idle
  task automatic run(logic p, logic on, logic off, logic sl, logic iv, logic fl, logic poke);
    @(negedge clk);
    ncap = 0;
    inv = iv; flip = fl;
    c_pwr = p; c_on = on; c_off = off; c_slp = sl;
    @(negedge clk);
    c_pwr = 0; c_on = 0; c_off = 0; c_slp = 0;
    if (poke) begin
      repeat (6) @(negedge clk);
      inv = ~iv; flip = ~fl;
      c_on = 1; c_off = 1; c_slp = 1; c_pwr = 1;
      @(negedge clk);
      c_on = 0; c_off = 0; c_slp = 0; c_pwr = 0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(string req);
    chk({req, " write count"}, ncap, nexp);
    for (int k = 0; k < nexp && k < ncap; k++) begin
      tests++;
      if (g_idx[k] !== e_idx[k] || g_io[k] !== e_io[k] ||
          (!e_io[k] && g_val[k] !== e_val[k])) begin
        fails++;
        $display("FAIL %s write %0d actual %h=%h io%b expected %h=%h io%b",
                 req, k, g_idx[k], g_val[k], g_io[k], e_idx[k], e_val[k], e_io[k]);
      end
      if (k > 0 && e_gap[k] > 0) begin
        int d = g_tk[k] - g_tk[k-1];
        tests++;
        if (d < e_gap[k] || d > e_gap[k] + 2) begin
          fails++;
          $display("FAIL R11 gap before write %0d actual %0d expected %0d", k, d, e_gap[k]);
        end
      end
    end
    nexp = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 powered", powered, 0); chk("R1 display_active", display_active, 0);
    chk("R1 busy", busy, 0);       chk("R1 wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3 power-up, no flip
    run(1, 0, 0, 0, 0, 0, 0);
    add_pu(0); compare("R2_R3 power-up");
    chk("R2 powered", powered, 1); chk("R2 display_active", display_active, 0);

    // R9 redundant power-up and display-off while inactive
    run(1, 0, 0, 0, 0, 0, 0); compare("R9 redundant power-up");
    run(0, 0, 1, 0, 0, 0, 0); compare("R9 off while inactive");

    // R5 resume while powered; R9/R12 pokes mid-run ignored
    run(0, 1, 0, 0, 0, 0, 1);
    add_resume(); add_tail(0); compare("R5_R9_R12 resume display-on");
    chk("R5 display_active", display_active, 1);

    // R9 display-on while active
    run(0, 1, 0, 0, 1, 0, 0); compare("R9 on while active");

    // R7/R6 display-off with invert
    run(0, 0, 1, 0, 1, 0, 0);
    add_off(1); compare("R7_R6 display-off inverted");
    chk("R7 display_active", display_active, 0); chk("R7 powered", powered, 1);

    // R6 resume with invert
    run(0, 1, 0, 0, 1, 0, 0);
    add_resume(); add_tail(1); compare("R6 display-on inverted");

    // R8 sleep while active
    run(0, 0, 0, 1, 0, 0, 0);
    add_off(0); push(8'h10, 16'h0001, 0, 0); compare("R8 sleep from active");
    chk("R8 powered", powered, 0); chk("R8 display_active", display_active, 0);

    // R4/R13 display-on from unpowered with flip; power-up also requested
    run(1, 1, 0, 0, 0, 1, 0);
    add_pu(1); add_tail(0); compare("R4_R13 cold display-on flipped");
    chk("R4 display_active", display_active, 1); chk("R4 powered", powered, 1);

    // R13 sleep beats display-off
    run(0, 0, 1, 1, 1, 0, 0);
    add_off(1); push(8'h10, 16'h0001, 0, 0); compare("R13 sleep priority");
    chk("R13 powered", powered, 0);

    // R8 sleep when already unpowered: standby only
    run(0, 0, 0, 1, 0, 0, 0);
    push(8'h10, 16'h0001, 0, 0); compare("R8 sleep unpowered");

    // R8 sleep when powered but inactive: standby only
    run(1, 0, 0, 0, 0, 0, 0); add_pu(0); compare("R2 second power-up");
    run(0, 0, 0, 1, 0, 0, 0);
    push(8'h10, 16'h0001, 0, 0); compare("R8 sleep powered inactive");
    chk("R8 powered after standby", powered, 0);

    summary();
    $finish;
  end
endmodule